// File: doc/BRIEF.md
# ChaCha Keystream XOR Core

This block runs the ChaCha permutation on a 16-word, 32-bit input state for a caller-chosen even number of rounds. It adds the starting state back word by word, then XORs that keystream block with a 64-byte data block to produce a 64-byte result. The state, data and result move on parallel 512-bit buses. Word `w` occupies bits `[32w+31:32w]`, so state word `w` sits at row `w/4` and column `w%4`. Byte `b` of the data block occupies bits `[8b+7:8b]` (little-endian). The caller controls the block with a start/busy/done handshake.

The state is held as four rows of four words. One cycle applies a full quarter-round to all four columns together. A column cycle ends by rotating rows 1, 2 and 3 left by 1, 2 and 3 word positions, which turns the diagonals into columns. The diagonal cycle that follows ends by rotating those rows by 3, 2 and 1 positions, which restores the original layout. A remaining-rounds counter drops by two after each diagonal cycle.

The controller has four states:
- `ST_IDLE`: waits for `start`. An accepted start goes to `ST_COLS`. A rejected start stays in `ST_IDLE` and raises `err`.
- `ST_COLS` always moves to `ST_DIAGS`.
- `ST_DIAGS` returns to `ST_COLS` while rounds remain, and goes to `ST_FEED` when the last pair finishes.
- `ST_FEED` registers the result, pulses `done`, and returns to `ST_IDLE`.

Top module: `chacha_xor_core`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and `result` is all zeros.
- R2: Each quarter-round step is, in order: row0 += row1, row3 = rotl(row3 ^ row0, 16); row2 += row3, row1 = rotl(row1 ^ row2, 12); row0 += row1, row3 = rotl(row3 ^ row0, 8); row2 += row3, row1 = rotl(row1 ^ row2, 7). All additions are modulo 2^32. With 20 rounds, the 20-round published test state (counter word 1) and zero data, the block gives the published keystream.
- R3: Rounds run in column/diagonal pairs. The diagonals are formed by rotating rows 1, 2 and 3 left by 1, 2 and 3 words and undone by rotating them by 3, 2 and 1. The remaining count stays even and nonzero while rounds run.
- R4: Result word `w` equals data word `w` XOR (permuted word `w` + original state word `w`). The byte order is little-endian: byte `b` is bits `[8b+7:8b]`.
- R5: Suppose `start` is sampled at edge E0 with an accepted count N. Then `busy` is high after edges E0 through E(N), and after edge E(N+1) `busy` is low and `done` is high with the new result. `done` and `busy` are never high together.
- R6: `done` is high for exactly one cycle.
- R7: `result` holds its value from `done` until the next run completes.
- R8: `start` is ignored while `busy` is high, and a run in progress keeps its own inputs.
- R9: A zero or odd `rounds` value at `start` sets `err` and starts nothing. `busy` stays low and `result` is unchanged. The next accepted `start` clears `err`.
- R10: The smallest count, 2, gives one column cycle and one diagonal cycle, and `done` arrives after edge E3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a block; sampled only when idle |
| rounds | input | ROUND_W | Round count, nonzero and even |
| state_in | input | 512 | Input state, word w at bits [32w+31:32w] |
| data_in | input | 512 | Data block, little-endian bytes |
| busy | output | 1 | High while rounds or the final add run |
| done | output | 1 | One-cycle pulse when result is updated |
| err | output | 1 | Last start had an invalid round count |
| result | output | 512 | Data XOR keystream |

## Verification
The bench builds the block with `ROUND_W` at its default of 8, so any even count from 2 to 254 is reachable. It uses 20, 12, 8 and 2, which covers the shortest schedule, a schedule long enough to hold a start injected mid-run, and the published 20-round vector. The same 8-bit width allows the rejected values 0 and 7. Every run is compared against a behavioural model that permutes a flat word array by explicit index quadruples, with no row rotation. The handshake is also compared on every clock of the run.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int ROWS    = 4;
    localparam int WORDS   = LANES * ROWS;
    localparam int BLOCK_W = WORDS * WORD_W;

    localparam int ROT_A = 16;
    localparam int ROT_B = 12;
    localparam int ROT_C = 8;
    localparam int ROT_D = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [LANES-1:0] row_t;
    typedef row_t  [ROWS-1:0]  state_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COLS  = 2'd1,
        ST_DIAGS = 2'd2,
        ST_FEED  = 2'd3
    } phase_t;

    function automatic word_t rotl(input word_t v, input int unsigned n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/chacha_qround.sv
module chacha_qround
    import chacha_pkg::*;
(
    input  state_t st_i,
    output state_t st_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        word_t a1, b1, c1, d1, a2, b2, c2, d2;
        always_comb begin
            a1 = st_i[0][g] + st_i[1][g];
            d1 = rotl(st_i[3][g] ^ a1, ROT_A);
            c1 = st_i[2][g] + d1;
            b1 = rotl(st_i[1][g] ^ c1, ROT_B);
            a2 = a1 + b1;
            d2 = rotl(d1 ^ a2, ROT_C);
            c2 = c1 + d2;
            b2 = rotl(b1 ^ c2, ROT_D);
        end
        assign st_o[0][g] = a2;
        assign st_o[1][g] = b2;
        assign st_o[2][g] = c2;
        assign st_o[3][g] = d2;
    end
endmodule

// File: rtl/chacha_row_shift.sv
module chacha_row_shift
    import chacha_pkg::*;
#(
    parameter bit RESTORE = 1'b0
) (
    input  state_t st_i,
    output state_t st_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int AMT = RESTORE ? ((LANES - r) % LANES) : r;
        for (genvar c = 0; c < LANES; c++) begin : g_col
            assign st_o[r][c] = st_i[r][(c + AMT) % LANES];
        end
    end
endmodule

// File: rtl/chacha_feedforward.sv
module chacha_feedforward
    import chacha_pkg::*;
(
    input  state_t             work_i,
    input  state_t             orig_i,
    input  logic [BLOCK_W-1:0] data_i,
    output logic [BLOCK_W-1:0] out_o
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign out_o[w*WORD_W +: WORD_W] =
            data_i[w*WORD_W +: WORD_W] ^ (work_i[w/LANES][w%LANES] + orig_i[w/LANES][w%LANES]);
    end
endmodule

// File: rtl/chacha_xor_core.sv
module chacha_xor_core
    import chacha_pkg::*;
#(
    parameter int ROUND_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ROUND_W-1:0] rounds,
    input  logic [BLOCK_W-1:0] state_in,
    input  logic [BLOCK_W-1:0] data_in,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [BLOCK_W-1:0] result
);
    localparam logic [ROUND_W-1:0] PAIR = ROUND_W'(2);

    phase_t             phase, phase_nx;
    state_t             work, orig;
    logic [BLOCK_W-1:0] data_q;
    logic [ROUND_W-1:0] left;

    state_t             qr_out, to_diag, to_cols;
    logic [BLOCK_W-1:0] ff_out;

    logic bad_count, accept, reject, last_pair;

    assign bad_count = rounds[0] || (rounds == '0);
    assign accept    = start && (phase == ST_IDLE) && !bad_count;
    assign reject    = start && (phase == ST_IDLE) && bad_count;
    assign last_pair = (left == PAIR);

    chacha_qround u_qround (
        .st_i (work),
        .st_o (qr_out)
    );

    chacha_row_shift #(.RESTORE(1'b0)) u_to_diag (
        .st_i (qr_out),
        .st_o (to_diag)
    );

    chacha_row_shift #(.RESTORE(1'b1)) u_to_cols (
        .st_i (qr_out),
        .st_o (to_cols)
    );

    chacha_feedforward u_ff (
        .work_i (work),
        .orig_i (orig),
        .data_i (data_q),
        .out_o  (ff_out)
    );

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_IDLE:  if (accept) phase_nx = ST_COLS;
            ST_COLS:  phase_nx = ST_DIAGS;
            ST_DIAGS: phase_nx = last_pair ? ST_FEED : ST_COLS;
            ST_FEED:  phase_nx = ST_IDLE;
            default:  phase_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= ST_IDLE;
        else        phase <= phase_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work   <= '0;
            orig   <= '0;
            data_q <= '0;
            left   <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (accept) begin
                        work   <= state_t'(state_in);
                        orig   <= state_t'(state_in);
                        data_q <= data_in;
                        left   <= rounds;
                        err    <= 1'b0;
                    end else if (reject) begin
                        err <= 1'b1;
                    end
                end
                ST_COLS:  work <= to_diag;
                ST_DIAGS: begin
                    work <= to_cols;
                    left <= left - PAIR;
                end
                ST_FEED: begin
                    result <= ff_out;
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (phase != ST_IDLE);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE) |=> $stable(result));

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (err && !busy));

    assert_even_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_COLS || phase == ST_DIAGS) |-> (!left[0] && left != '0));

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(orig) && $stable(data_q)));
endmodule

// File: tb/test_chacha_xor_core.sv
module test_chacha_xor_core;
    localparam int RW = 8;
    localparam int BW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] rounds = '0;
    logic [BW-1:0] state_in = '0;
    logic [BW-1:0] data_in = '0;
    logic          busy, done, err;
    logic [BW-1:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chacha_xor_core #(.ROUND_W(RW)) i_chacha_xor_core (
        .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
        .state_in(state_in), .data_in(data_in),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [BW-1:0] model(input logic [BW-1:0] s, input logic [BW-1:0] d, input int n);
        logic [31:0] x[16];
        logic [BW-1:0] o;
        int qa[8] = '{0, 1, 2, 3, 0, 1, 2, 3};
        int qb[8] = '{4, 5, 6, 7, 5, 6, 7, 4};
        int qc[8] = '{8, 9, 10, 11, 10, 11, 8, 9};
        int qd[8] = '{12, 13, 14, 15, 15, 12, 13, 14};
        for (int i = 0; i < 16; i++) x[i] = s[i*32 +: 32];
        for (int r = 0; r < n; r += 2) begin
            for (int q = 0; q < 8; q++) begin
                x[qa[q]] = x[qa[q]] + x[qb[q]]; x[qd[q]] = rl(x[qd[q]] ^ x[qa[q]], 16);
                x[qc[q]] = x[qc[q]] + x[qd[q]]; x[qb[q]] = rl(x[qb[q]] ^ x[qc[q]], 12);
                x[qa[q]] = x[qa[q]] + x[qb[q]]; x[qd[q]] = rl(x[qd[q]] ^ x[qa[q]], 8);
                x[qc[q]] = x[qc[q]] + x[qd[q]]; x[qb[q]] = rl(x[qb[q]] ^ x[qc[q]], 7);
            end
        end
        for (int i = 0; i < 16; i++) o[i*32 +: 32] = d[i*32 +: 32] ^ (x[i] + s[i*32 +: 32]);
        return o;
    endfunction

    function automatic logic [BW-1:0] rand_block();
        logic [BW-1:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Drives one block; checks busy/done on every clock; optional injected start mid-run.
    task automatic run(input logic [BW-1:0] s, input logic [BW-1:0] d, input int n,
                       input bit inject, input string tag, output logic [BW-1:0] got);
        logic [BW-1:0] exp;
        bit hs_ok;
        exp = model(s, d, n);
        @(negedge clk);
        start = 1'b1; rounds = RW'(n); state_in = s; data_in = d;
        @(negedge clk);
        start = 1'b0;
        hs_ok = 1'b1;
        for (int j = 0; j <= n; j++) begin
            if (!(busy === 1'b1 && done === 1'b0)) hs_ok = 1'b0;
            if (inject && j == 2) begin
                start = 1'b1; state_in = rand_block(); data_in = rand_block(); rounds = RW'(2);
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(hs_ok, {"R5 busy window ", tag}, BW'(hs_ok), BW'(1));
        check(done === 1'b1 && busy === 1'b0, {"R5 done timing ", tag}, BW'({done, busy}), BW'(2'b10));
        check(result === exp, {"R4 result ", tag}, result, exp);
        got = result;
        @(negedge clk);
        check(done === 1'b0, {"R6 done pulse ", tag}, BW'(done), BW'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] kst, kexp, got, got0, s1, d1, held;
        logic [31:0] kin[16] = '{32'h61707865, 32'h3320646e, 32'h79622d32, 32'h6b206574,
                                 32'h03020100, 32'h07060504, 32'h0b0a0908, 32'h0f0e0d0c,
                                 32'h13121110, 32'h17161514, 32'h1b1a1918, 32'h1f1e1d1c,
                                 32'h00000001, 32'h09000000, 32'h4a000000, 32'h00000000};
        logic [31:0] kout[16] = '{32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
                                  32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
                                  32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
                                  32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};
        bit quiet;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags", BW'({busy, done, err}), BW'(0));
        check(result === '0, "R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 published vector, zero data, 20 rounds
        for (int i = 0; i < 16; i++) begin kst[i*32 +: 32] = kin[i]; kexp[i*32 +: 32] = kout[i]; end
        run(kst, '0, 20, 1'b0, "vec20", got);
        check(got === kexp, "R2 known keystream", got, kexp);

        // R3 diagonal/column schedule at 8 rounds
        s1 = rand_block(); d1 = rand_block();
        run(s1, d1, 8, 1'b0, "r8", got);

        // R4 byte order: flip only byte 5
        run(s1, '0, 8, 1'b0, "ks8", got0);
        run(s1, BW'(64'hFF) << 40, 8, 1'b0, "byte5", got);
        check(got[47:40] === (got0[47:40] ^ 8'hFF) && got[39:0] === got0[39:0] && got[BW-1:48] === got0[BW-1:48],
              "R4 little-endian byte 5", got, got0 ^ (BW'(64'hFF) << 40));

        // R8 start while busy ignored
        run(rand_block(), rand_block(), 12, 1'b1, "r12_inject", got);

        // R10 minimum count
        run(rand_block(), rand_block(), 2, 1'b0, "r2_min", got);

        // R7 result held while idle
        held = result;
        repeat (10) @(negedge clk);
        check(result === held && busy === 1'b0, "R7 hold", result, held);

        // R9 odd count rejected
        @(negedge clk);
        start = 1'b1; rounds = RW'(7); state_in = rand_block();
        @(negedge clk);
        start = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < 5; k++) begin
            if (busy !== 1'b0 || done !== 1'b0) quiet = 1'b0;
            @(negedge clk);
        end
        check(err === 1'b1, "R9 odd err", BW'(err), BW'(1));
        check(quiet && result === held, "R9 odd no run", result, held);

        // R9 zero count rejected
        start = 1'b1; rounds = '0;
        @(negedge clk);
        start = 1'b0;
        check(err === 1'b1 && busy === 1'b0, "R9 zero err", BW'({err, busy}), BW'(2'b10));

        // R9 err cleared by next accepted start
        run(rand_block(), rand_block(), 8, 1'b0, "after_err", got);
        check(err === 1'b0, "R9 err cleared", BW'(err), BW'(0));

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule